// File: doc/BRIEF.md
# RTC Time and Alarm Register Bank

This block is the register-facing core of a real-time clock. It keeps a seconds count as a 32-bit unsigned number. The count moves forward once for every pulse on a one-per-second strobe, which an external timebase supplies. Software can program a new time. The new value waits in a holding register and can be read back from there until the next second pulse, which loads it into the running count.

A programmable alarm value is compared against the count. The block records two events in a status register: every second pulse, and the moment the count becomes equal to the alarm. Writing a one to a status bit clears it. Each event source is switched on by writing a one to an enable address and switched off by writing a one to a separate disable address. The resulting mask can be read back. The two interrupt lines are registered levels.

A control word holds a supply-switch enable and an oscillator enable. A calibration word is stored and can be read back. A free-running tick count reports the clock cycles elapsed since the last second pulse. Reads return data one cycle after the read strobe.

Top module: `rtc_time_alarm`

## Requirements
- R1: After reset, the current time, the alarm, the set-time holding value, the calibration, the status, the mask, the control word and both interrupt lines are all zero.
- R2: A write to offset 0x00 is readable at offset 0x04 on the next read. The current time at offset 0x10 does not change until a second pulse arrives.
- R3: On each second pulse, the time loads the held set-time value if a set-time write arrived since the previous pulse, and otherwise adds one, wrapping from 0xFFFFFFFF to 0.
- R4: Status bit 0 (offset 0x20) is set by every second pulse.
- R5: Status bit 1 is set when the current time becomes equal to the alarm (offset 0x18, read/write). This includes an alarm written to equal the present time.
- R6: Writing a one to a status bit clears it, and writing a zero leaves it unchanged. When a clear and a new event hit the same bit in the same cycle, the bit ends set.
- R7: Writing a one to bit n at offset 0x28 sets mask bit n. Writing a one to bit n at offset 0x2C clears it. The mask is read at offset 0x24, with bit 0 for the second source and bit 1 for the alarm source.
- R8: Each interrupt line equals its status bit ANDed with its mask bit, registered one cycle later. It stays high until either of the two is cleared.
- R9: Control offset 0x40 keeps bit 31 (supply switch enable) and bit 24 (oscillator enable) as read/write bits. All its other bits read as zero.
- R10: The low 21 bits of a write to offset 0x08 are readable at offset 0x0C, and the upper bits read as zero.
- R11: Offset 0x14 reads the number of clock cycles since the last second pulse. It is zero in the cycle after the pulse and saturates at its all-ones value.
- R12: Read data appears on the cycle after the read strobe. Write-only offsets (0x00, 0x08, 0x28, 0x2C) and unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd_en |
| sec_pulse | input | 1 | One-cycle strobe, once per second |
| irq_alarm | output | 1 | Alarm interrupt level |
| irq_second | output | 1 | Second interrupt level |

## Verification
The bench builds the block with a 4-bit tick counter. With that width, saturation is reached after a few dozen idle cycles instead of tens of thousands, so the limit behaviour of R11 is checked directly. The address width and the 21-bit calibration width stay at their defaults, so every mapped and unmapped offset is decoded exactly as in the full-size block. The seconds count keeps its full 32 bits, so the wrap from all-ones to zero is reached by programming the count rather than by waiting for it.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned DW = 32;

  // register offsets (software decodes these)
  localparam logic [15:0] OFS_SET_WR  = 16'h0000;
  localparam logic [15:0] OFS_SET_RD  = 16'h0004;
  localparam logic [15:0] OFS_CAL_WR  = 16'h0008;
  localparam logic [15:0] OFS_CAL_RD  = 16'h000C;
  localparam logic [15:0] OFS_TIME    = 16'h0010;
  localparam logic [15:0] OFS_TICK    = 16'h0014;
  localparam logic [15:0] OFS_ALARM   = 16'h0018;
  localparam logic [15:0] OFS_STATUS  = 16'h0020;
  localparam logic [15:0] OFS_MASK    = 16'h0024;
  localparam logic [15:0] OFS_IRQ_ON  = 16'h0028;
  localparam logic [15:0] OFS_IRQ_OFF = 16'h002C;
  localparam logic [15:0] OFS_CTRL    = 16'h0040;

  // interrupt sources, bit positions in status / mask
  localparam int unsigned N_SRC   = 2;
  localparam int unsigned SRC_SEC = 0;
  localparam int unsigned SRC_ALM = 1;

  // control bits
  localparam int unsigned CTRL_SUPPLY = 31;
  localparam int unsigned CTRL_OSC    = 24;

  typedef struct packed {
    logic set_time;
    logic calib;
    logic alarm;
    logic stat_clr;
    logic src_on;
    logic src_off;
    logic ctrl;
  } wr_sel_t;
endpackage

// File: rtl/rtc_time_counter.sv
module rtc_time_counter #(
  parameter int unsigned DW     = 32,
  parameter int unsigned TICK_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sec_pulse,
  input  logic              set_we,
  input  logic [DW-1:0]     set_val,
  input  logic [DW-1:0]     alarm_val,
  output logic [DW-1:0]     time_o,
  output logic [DW-1:0]     held_o,
  output logic              held_vld_o,
  output logic [TICK_W-1:0] tick_o,
  output logic              alarm_hit_o
);
  localparam logic [TICK_W-1:0] TICK_MAX = {TICK_W{1'b1}};

  logic [DW-1:0]     time_q, held_q;
  logic              held_vld_q;
  logic [TICK_W-1:0] tick_q;
  logic              eq_q;
  logic              eq_now;

  assign eq_now = (time_q == alarm_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      time_q     <= '0;
      held_q     <= '0;
      held_vld_q <= 1'b0;
      tick_q     <= '0;
      eq_q       <= 1'b1;
    end else begin
      if (set_we) held_q <= set_val;
      if (set_we)         held_vld_q <= 1'b1;
      else if (sec_pulse) held_vld_q <= 1'b0;
      if (sec_pulse) time_q <= held_vld_q ? held_q : time_q + 1'b1;
      if (sec_pulse)              tick_q <= '0;
      else if (tick_q != TICK_MAX) tick_q <= tick_q + 1'b1;
      eq_q <= eq_now;
    end
  end

  assign time_o      = time_q;
  assign held_o      = held_q;
  assign held_vld_o  = held_vld_q;
  assign tick_o      = tick_q;
  assign alarm_hit_o = eq_now && !eq_q;
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl #(
  parameter int unsigned NS = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NS-1:0] event_i,
  input  logic          clr_we,
  input  logic          on_we,
  input  logic          off_we,
  input  logic [NS-1:0] wbits,
  output logic [NS-1:0] status_o,
  output logic [NS-1:0] mask_o,
  output logic [NS-1:0] irq_o
);
  logic [NS-1:0] status_q, mask_q, irq_q;

  for (genvar i = 0; i < NS; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst) begin
        status_q[i] <= 1'b0;
        mask_q[i]   <= 1'b0;
        irq_q[i]    <= 1'b0;
      end else begin
        // a new event overrides a simultaneous clear
        status_q[i] <= event_i[i] | (status_q[i] & ~(clr_we & wbits[i]));
        if (on_we && wbits[i])       mask_q[i] <= 1'b1;
        else if (off_we && wbits[i]) mask_q[i] <= 1'b0;
        irq_q[i] <= status_q[i] & mask_q[i];
      end
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/rtc_cfg_regs.sv
module rtc_cfg_regs #(
  parameter int unsigned DW    = 32,
  parameter int unsigned CAL_W = 21
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alarm_we,
  input  logic             cal_we,
  input  logic             ctrl_we,
  input  logic [DW-1:0]    alarm_wd,
  input  logic [CAL_W-1:0] cal_wd,
  input  logic             supply_wd,
  input  logic             osc_wd,
  output logic [DW-1:0]    alarm_o,
  output logic [CAL_W-1:0] cal_o,
  output logic             supply_o,
  output logic             osc_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      alarm_o  <= '0;
      cal_o    <= '0;
      supply_o <= 1'b0;
      osc_o    <= 1'b0;
    end else begin
      if (alarm_we) alarm_o <= alarm_wd;
      if (cal_we)   cal_o   <= cal_wd;
      if (ctrl_we) begin
        supply_o <= supply_wd;
        osc_o    <= osc_wd;
      end
    end
  end
endmodule

// File: rtl/rtc_bus_read.sv
module rtc_bus_read #(
  parameter int unsigned DW     = 32,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CAL_W  = 21,
  parameter int unsigned TICK_W = 16,
  parameter int unsigned NS     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DW-1:0]     time_v,
  input  logic [DW-1:0]     held_v,
  input  logic [DW-1:0]     alarm_v,
  input  logic [CAL_W-1:0]  cal_v,
  input  logic [TICK_W-1:0] tick_v,
  input  logic [NS-1:0]     status_v,
  input  logic [NS-1:0]     mask_v,
  input  logic              supply_v,
  input  logic              osc_v,
  output logic [DW-1:0]     rdata_o
);
  import rtc_pkg::*;

  logic [DW-1:0] mux;
  logic [DW-1:0] ctrl_word;

  always_comb begin
    ctrl_word              = '0;
    ctrl_word[CTRL_SUPPLY] = supply_v;
    ctrl_word[CTRL_OSC]    = osc_v;
  end

  always_comb begin
    case (16'(rd_addr))
      OFS_SET_RD: mux = held_v;
      OFS_CAL_RD: mux = DW'(cal_v);
      OFS_TIME:   mux = time_v;
      OFS_TICK:   mux = DW'(tick_v);
      OFS_ALARM:  mux = alarm_v;
      OFS_STATUS: mux = DW'(status_v);
      OFS_MASK:   mux = DW'(mask_v);
      OFS_CTRL:   mux = ctrl_word;
      default:    mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_o <= '0;
    else if (rd_en) rdata_o <= mux;
  end
endmodule

// File: rtl/rtc_time_alarm.sv
module rtc_time_alarm #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CAL_W  = 21,
  parameter int unsigned TICK_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              sec_pulse,
  output logic              irq_alarm,
  output logic              irq_second
);
  import rtc_pkg::*;

  wr_sel_t           wsel;
  logic [DW-1:0]     time_val, held_val, alarm_val;
  logic              held_vld, alarm_hit;
  logic [TICK_W-1:0] tick_val;
  logic [CAL_W-1:0]  cal_val;
  logic              supply_en, osc_en;
  logic [N_SRC-1:0]  src_event, stat_val, mask_val, irq_vec;

  always_comb begin
    wsel          = '0;
    wsel.set_time = bus_wr_en && (16'(bus_addr) == OFS_SET_WR);
    wsel.calib    = bus_wr_en && (16'(bus_addr) == OFS_CAL_WR);
    wsel.alarm    = bus_wr_en && (16'(bus_addr) == OFS_ALARM);
    wsel.stat_clr = bus_wr_en && (16'(bus_addr) == OFS_STATUS);
    wsel.src_on   = bus_wr_en && (16'(bus_addr) == OFS_IRQ_ON);
    wsel.src_off  = bus_wr_en && (16'(bus_addr) == OFS_IRQ_OFF);
    wsel.ctrl     = bus_wr_en && (16'(bus_addr) == OFS_CTRL);
  end

  rtc_cfg_regs #(.DW(DW), .CAL_W(CAL_W)) u_cfg (
    .clk(clk), .rst(rst),
    .alarm_we(wsel.alarm), .cal_we(wsel.calib), .ctrl_we(wsel.ctrl),
    .alarm_wd(bus_wdata), .cal_wd(bus_wdata[CAL_W-1:0]),
    .supply_wd(bus_wdata[CTRL_SUPPLY]), .osc_wd(bus_wdata[CTRL_OSC]),
    .alarm_o(alarm_val), .cal_o(cal_val), .supply_o(supply_en), .osc_o(osc_en)
  );

  rtc_time_counter #(.DW(DW), .TICK_W(TICK_W)) u_cnt (
    .clk(clk), .rst(rst), .sec_pulse(sec_pulse),
    .set_we(wsel.set_time), .set_val(bus_wdata), .alarm_val(alarm_val),
    .time_o(time_val), .held_o(held_val), .held_vld_o(held_vld),
    .tick_o(tick_val), .alarm_hit_o(alarm_hit)
  );

  always_comb begin
    src_event          = '0;
    src_event[SRC_SEC] = sec_pulse;
    src_event[SRC_ALM] = alarm_hit;
  end

  rtc_irq_ctrl #(.NS(N_SRC)) u_irq (
    .clk(clk), .rst(rst), .event_i(src_event),
    .clr_we(wsel.stat_clr), .on_we(wsel.src_on), .off_we(wsel.src_off),
    .wbits(bus_wdata[N_SRC-1:0]),
    .status_o(stat_val), .mask_o(mask_val), .irq_o(irq_vec)
  );

  rtc_bus_read #(.DW(DW), .ADDR_W(ADDR_W), .CAL_W(CAL_W), .TICK_W(TICK_W), .NS(N_SRC)) u_rd (
    .clk(clk), .rst(rst), .rd_en(bus_rd_en), .rd_addr(bus_addr),
    .time_v(time_val), .held_v(held_val), .alarm_v(alarm_val), .cal_v(cal_val),
    .tick_v(tick_val), .status_v(stat_val), .mask_v(mask_val),
    .supply_v(supply_en), .osc_v(osc_en), .rdata_o(bus_rdata)
  );

  assign irq_alarm  = irq_vec[SRC_ALM];
  assign irq_second = irq_vec[SRC_SEC];
endmodule

// File: rtl/rtc_time_alarm_chk.sv
module rtc_time_alarm_chk #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              sec_pulse,
  input logic              bus_wr_en,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       time_val,
  input logic              held_vld,
  input logic [31:0]       held_val,
  input logic [1:0]        stat_val,
  input logic [1:0]        mask_val,
  input logic              irq_alarm,
  input logic              irq_second
);
  assert_irq_low_after_reset_R1: assert property (@(posedge clk)
    rst |=> (!irq_alarm && !irq_second));

  assert_time_holds_without_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    !sec_pulse |=> $stable(time_val));

  assert_time_increments_R3: assert property (@(posedge clk) disable iff (rst)
    (sec_pulse && !held_vld) |=> (time_val == $past(time_val) + 32'd1));

  assert_time_loads_held_R3: assert property (@(posedge clk) disable iff (rst)
    (sec_pulse && held_vld) |=> (time_val == $past(held_val)));

  assert_second_status_set_R4: assert property (@(posedge clk) disable iff (rst)
    sec_pulse |=> stat_val[0]);

  assert_disable_clears_mask_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_en && (16'(bus_addr) == 16'h002C) && bus_wdata[1]) |=> !mask_val[1]);

  assert_second_line_follows_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_second == $past(stat_val[0] & mask_val[0])));

  assert_alarm_line_follows_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_alarm == $past(stat_val[1] & mask_val[1])));
endmodule

bind rtc_time_alarm rtc_time_alarm_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .sec_pulse(sec_pulse), .bus_wr_en(bus_wr_en),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .time_val(time_val),
  .held_vld(held_vld), .held_val(held_val), .stat_val(stat_val),
  .mask_val(mask_val), .irq_alarm(irq_alarm), .irq_second(irq_second)
);

// File: tb/rtc_time_alarm_tb_top.sv
`timescale 1ns/1ps
module rtc_time_alarm_tb_top;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned TICK_W = 4;

  logic              clk = 1'b0;
  logic              rst;
  logic              bus_wr_en, bus_rd_en, sec_pulse;
  logic [ADDR_W-1:0] bus_addr;
  logic [31:0]       bus_wdata, bus_rdata;
  logic              irq_alarm, irq_second;

  always #2.5 clk = ~clk;

  rtc_time_alarm #(.ADDR_W(ADDR_W), .CAL_W(21), .TICK_W(TICK_W)) dut_i (
    .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sec_pulse(sec_pulse), .irq_alarm(irq_alarm), .irq_second(irq_second)
  );

  typedef struct {
    logic [31:0] exp;
    string       req;
    logic [7:0]  addr;
  } sb_item_t;

  sb_item_t sb_q[$];
  int n_cmp = 0;
  int n_bad = 0;
  logic rd_d = 1'b0;
  bit done = 1'b0;

  task automatic compare(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // monitor: read data is valid at the negedge after the sampling posedge (R12)
  always @(posedge clk) rd_d <= bus_rd_en;
  always @(negedge clk) begin
    if (rd_d) begin
      if (sb_q.size() == 0) compare("R12 unexpected read", bus_rdata, 32'h0);
      else begin
        sb_item_t it;
        it = sb_q.pop_front();
        compare(it.req, bus_rdata, it.exp);
      end
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] e, string req);
    sb_item_t it;
    it.exp = e; it.req = req; it.addr = a;
    sb_q.push_back(it);
    bus_rd_en = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd_en = 1'b0;
  endtask

  task automatic pulse();
    sec_pulse = 1'b1;
    @(negedge clk);
    sec_pulse = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; bus_wr_en = 1'b0; bus_rd_en = 1'b0; sec_pulse = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(8'h10, 32'h0, "R1 time");
    rd(8'h18, 32'h0, "R1 alarm");
    rd(8'h20, 32'h0, "R1 status");
    rd(8'h24, 32'h0, "R1 mask");
    rd(8'h40, 32'h0, "R1 control");
    rd(8'h0C, 32'h0, "R1 calibration");
    rd(8'h04, 32'h0, "R1 held time");
    compare("R1 irq_alarm", {31'b0, irq_alarm}, 32'h0);
    compare("R1 irq_second", {31'b0, irq_second}, 32'h0);

    // R2 held value visible, time unchanged
    wr(8'h00, 32'd4);
    rd(8'h04, 32'd4, "R2 held readback");
    rd(8'h10, 32'd0, "R2 time before pulse");

    // R3 load, R4 second status
    pulse();
    rd(8'h10, 32'd4, "R3 load held time");
    rd(8'h20, 32'h1, "R4 second status");
    pulse();
    rd(8'h10, 32'd5, "R3 increment");

    wr(8'h18, 32'd7);
    rd(8'h18, 32'd7, "R5 alarm readback");
    wr(8'h20, 32'h3);
    rd(8'h20, 32'h0, "R6 clear both");
    wr(8'h28, 32'h3);
    rd(8'h24, 32'h3, "R7 enable mask");

    // R5 alarm reached by counting
    pulse();
    pulse();
    idle(3);
    rd(8'h20, 32'h3, "R5 alarm event");
    compare("R8 irq_alarm high", {31'b0, irq_alarm}, 32'h1);
    compare("R8 irq_second high", {31'b0, irq_second}, 32'h1);

    wr(8'h20, 32'h0);
    rd(8'h20, 32'h3, "R6 write zero no effect");

    wr(8'h20, 32'h1);
    idle(2);
    rd(8'h20, 32'h2, "R6 clear second only");
    compare("R8 irq_second dropped", {31'b0, irq_second}, 32'h0);
    compare("R8 irq_alarm held", {31'b0, irq_alarm}, 32'h1);

    wr(8'h2C, 32'h2);
    idle(2);
    rd(8'h24, 32'h1, "R7 disable mask");
    compare("R8 irq_alarm masked", {31'b0, irq_alarm}, 32'h0);
    rd(8'h20, 32'h2, "R7 status kept when masked");

    // R5 alarm written equal to present time (7)
    wr(8'h20, 32'h3);
    wr(8'h18, 32'd9);
    wr(8'h18, 32'd7);
    idle(2);
    rd(8'h20, 32'h2, "R5 alarm equals present time");

    // R6 same-cycle clear and event
    sec_pulse = 1'b1; bus_wr_en = 1'b1; bus_addr = 8'h20; bus_wdata = 32'h3;
    @(negedge clk);
    sec_pulse = 1'b0; bus_wr_en = 1'b0;
    idle(1);
    rd(8'h20, 32'h1, "R6 event beats clear");

    // R3 wrap
    wr(8'h00, 32'hFFFF_FFFF);
    pulse();
    rd(8'h10, 32'hFFFF_FFFF, "R3 load all-ones");
    pulse();
    rd(8'h10, 32'h0, "R3 wrap to zero");

    // R11 tick counter
    pulse();
    rd(8'h14, 32'd0, "R11 tick after pulse");
    rd(8'h14, 32'd1, "R11 tick counting");
    idle(30);
    rd(8'h14, 32'd15, "R11 tick saturates");

    // R9 control
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h40, 32'h8100_0000, "R9 control bits only");
    wr(8'h40, 32'h0100_0000);
    rd(8'h40, 32'h0100_0000, "R9 oscillator alone");

    // R10 calibration, R12 write-only / unmapped
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h0C, 32'h001F_FFFF, "R10 calibration width");
    rd(8'h08, 32'h0, "R12 write-only calib");
    rd(8'h28, 32'h0, "R12 write-only enable");
    rd(8'h30, 32'h0, "R12 unmapped");

    idle(3);
    compare("R12 scoreboard drained", 32'(sb_q.size()), 32'h0);
    finish_run();
  end
endmodule